// File: doc/BRIEF.md
# Scanned Hex Keypad Decoder

This block reads a 4x4 matrix keypad. It pulls one row line low at a time and reads the four column lines back. A free-running prescaler sets how long each row stays selected. One full pass over the four rows is a scan frame. A key is taken as pressed only when several consecutive frames agree on it. The accepted key is converted to a hexadecimal digit and shown as an 8-bit seven-segment pattern.

The block drives a single display digit, so its enable line is tied high. The key-valid strobe pulses once for each accepted press. A host can count presses from it, or latch the digit when it fires. Column inputs pass through a synchronizer before the block uses them.

Top module: `hex_keypad_decoder`

## Requirements
- R1: `row_o` is a ring with exactly one bit low. It resets to 1110 and then steps through 0111, 1011, 1101, 1110 and repeats. Row r is driven on `row_o` bit 3-r.
- R2: Each row stays selected for exactly 2^PRESC_W clock cycles.
- R3: Columns are active low, and column c is `col_i` bit 3-c. A key at row r and column c gives one digit. Row 0 gives 1, 2, 3, F. Row 1 gives 4, 5, 6, E. Row 2 gives 7, 8, 9, D. Row 3 gives 0, A, B, C. In each row, column 0 is the first value listed.
- R4: `seg_o[7]` is 0 and `seg_o[6:0]` holds the active-high segments g down to a. The patterns are 0=3F, 1=06, 2=5B, 3=4F, 4=66, 5=6D, 6=7D, 7=07, 8=7F, 9=6F, A=77, b=7C, C=39, d=5E, E=79, F=71.
- R5: A scan frame ends at the step that leaves row 3. A key is accepted only after DEB_FRAMES consecutive frames report that same single key. A shorter press has no effect on any output.
- R6: `key_valid_o` is high for exactly one cycle per accepted press. A key that stays held does not fire it again.
- R7: After an acceptance, no new key is accepted until DEB_FRAMES consecutive frames read no key. A quick re-press leaves the outputs unchanged.
- R8: In some frames more than one column reads low in a step, or keys are seen in more than one row. Such a frame is discarded and the agreement count restarts, so a multi-key press is never accepted.
- R9: `seg_o` holds the pattern of the last accepted digit and changes only in the cycle `key_valid_o` is high. After reset it reads 00.
- R10: `digit_en_o` is always 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| col_i | input | 4 | Keypad column lines, active low |
| row_o | output | 4 | Keypad row drive, one bit low |
| seg_o | output | 8 | Seven-segment pattern {0, g..a} |
| digit_en_o | output | 1 | Display digit enable, constant 1 |
| key_valid_o | output | 1 | One-cycle pulse per accepted key |

## Verification
The bench presses all sixteen keys in turn. A wrong row or column mapping shows up as a wrong segment byte. It also times every row step, so an off-by-one in the prescaler shows up as a wrong dwell.

Several cases target the debounce logic:
- A press shorter than the agreement window must not be accepted. A design that counts too few frames accepts it.
- A re-press after too short a release must be refused. A design that re-arms too early gives an extra strobe.
- A long hold must not repeat. A design that re-fires on every saturated count gives repeated strobes.
- A burst of contact bounce must still give exactly one strobe.

Two chords are pressed: one with both keys in a single row, and one with keys in different rows. Neither may give a digit. A design that decodes only the lowest low column would show one anyway.

// File: rtl/hexkp_pkg.sv
package hexkp_pkg;
  localparam int KP_N = 4;

  typedef enum logic [1:0] {FR_NONE = 2'd0, FR_ONE = 2'd1, FR_MULTI = 2'd2} frame_e;

  // keypad position -> hex digit
  function automatic logic [3:0] key_digit(input logic [1:0] r, input logic [1:0] c);
    logic [3:0] d;
    if (r == 2'd3)      d = (c == 2'd0) ? 4'h0 : 4'd9 + {2'b00, c};
    else if (c == 2'd3) d = 4'hF - {2'b00, r};
    else                d = 4'd3 * {2'b00, r} + {2'b00, c} + 4'd1;
    return d;
  endfunction

  function automatic logic [6:0] seg_of(input logic [3:0] d);
    logic [6:0] s;
    case (d)
      4'h0: s = 7'h3F; 4'h1: s = 7'h06; 4'h2: s = 7'h5B; 4'h3: s = 7'h4F;
      4'h4: s = 7'h66; 4'h5: s = 7'h6D; 4'h6: s = 7'h7D; 4'h7: s = 7'h07;
      4'h8: s = 7'h7F; 4'h9: s = 7'h6F; 4'hA: s = 7'h77; 4'hB: s = 7'h7C;
      4'hC: s = 7'h39; 4'hD: s = 7'h5E; 4'hE: s = 7'h79; default: s = 7'h71;
    endcase
    return s;
  endfunction
endpackage

// File: rtl/kp_row_scan.sv
module kp_row_scan #(
  parameter int PRESC_W = 10
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  output logic [3:0] row_o,
  output logic [1:0] row_idx_o,
  output logic       step_o,
  output logic       last_o
);
  logic [PRESC_W-1:0] presc_q;
  logic [3:0]         row_q;

  assign step_o = &presc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      presc_q <= '0;
      row_q   <= 4'b1110;
    end else begin
      presc_q <= presc_q + 1'b1;
      if (step_o) row_q <= {row_q[0], row_q[3:1]};
    end
  end

  always_comb begin
    row_idx_o = 2'd0;
    for (int r = 0; r < 4; r++)
      if (!row_q[3-r]) row_idx_o = 2'(r);
  end

  assign last_o = (row_q == 4'b1110);
  assign row_o  = row_q;

  AST_ROW_ONE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(~row_o) == 1); // R1
  AST_ROW_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_o |=> $stable(row_o)); // R2
endmodule

// File: rtl/kp_col_sync.sv
module kp_col_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] s_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s_q <= '1;
    end else begin
      s_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) s_q[i] <= s_q[i-1];
    end
  end

  assign q_o = s_q[STAGES-1];
endmodule

// File: rtl/kp_debounce.sv
module kp_debounce
  import hexkp_pkg::*;
#(
  parameter int DEB_FRAMES = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       step_i,
  input  logic       last_i,
  input  logic [1:0] row_idx_i,
  input  logic [3:0] col_i,
  output logic       valid_o,
  output logic       seen_o,
  output logic [3:0] digit_o
);
  localparam int CW = $clog2(DEB_FRAMES + 1);
  localparam logic [CW-1:0] DEB = CW'(DEB_FRAMES);

  frame_e        acc_kind_q, cand_kind_q, st_kind, m_kind;
  logic [3:0]    acc_code_q, cand_code_q, st_code, m_code;
  logic [1:0]    st_col;
  logic [3:0]    low;
  logic [CW-1:0] cnt_q, cnt_n;
  logic          same, armed_q, valid_q, seen_q;
  logic [3:0]    digit_q;

  assign low = ~col_i;

  always_comb begin
    st_col = 2'd0;
    for (int c = 0; c < 4; c++)
      if (low[3-c]) st_col = 2'(c);
    case ($countones(low))
      0:       st_kind = FR_NONE;
      1:       st_kind = FR_ONE;
      default: st_kind = FR_MULTI;
    endcase
    st_code = key_digit(row_idx_i, st_col);
    // fold this row step into the running frame result
    if (acc_kind_q == FR_MULTI || st_kind == FR_MULTI ||
        (acc_kind_q == FR_ONE && st_kind == FR_ONE)) begin
      m_kind = FR_MULTI; m_code = acc_code_q;
    end else if (st_kind == FR_ONE) begin
      m_kind = FR_ONE;   m_code = st_code;
    end else begin
      m_kind = acc_kind_q; m_code = acc_code_q;
    end
    same  = (cand_kind_q == m_kind) && (m_kind != FR_ONE || cand_code_q == m_code);
    cnt_n = !same ? CW'(1) : (cnt_q == DEB) ? cnt_q : cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_kind_q  <= FR_NONE;
      acc_code_q  <= '0;
      cand_kind_q <= FR_NONE;
      cand_code_q <= '0;
      cnt_q       <= '0;
      armed_q     <= 1'b1;
      valid_q     <= 1'b0;
      seen_q      <= 1'b0;
      digit_q     <= '0;
    end else begin
      valid_q <= 1'b0;
      if (step_i) begin
        if (!last_i) begin
          acc_kind_q <= m_kind;
          acc_code_q <= m_code;
        end else begin
          acc_kind_q <= FR_NONE;
          if (m_kind == FR_MULTI) begin
            cand_kind_q <= FR_MULTI;
            cnt_q       <= '0;
          end else begin
            cand_kind_q <= m_kind;
            cand_code_q <= m_code;
            cnt_q       <= cnt_n;
            if (cnt_n == DEB) begin
              if (m_kind == FR_ONE && armed_q) begin
                valid_q <= 1'b1;
                digit_q <= m_code;
                seen_q  <= 1'b1;
                armed_q <= 1'b0;
              end else if (m_kind == FR_NONE) begin
                armed_q <= 1'b1;
              end
            end
          end
        end
      end
    end
  end

  assign valid_o = valid_q;
  assign seen_o  = seen_q;
  assign digit_o = digit_q;

  AST_ONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q |=> !valid_q); // R6
  AST_CNT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= DEB); // R5
  AST_MULTI_NO_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && last_i && m_kind == FR_MULTI) |=> !valid_q); // R8
endmodule

// File: rtl/hex_keypad_decoder.sv
module hex_keypad_decoder
  import hexkp_pkg::*;
#(
  parameter int PRESC_W     = 10,
  parameter int DEB_FRAMES  = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [3:0] col_i,
  output logic [3:0] row_o,
  output logic [7:0] seg_o,
  output logic       digit_en_o,
  output logic       key_valid_o
);
  logic [1:0] row_idx;
  logic       step, last, seen;
  logic [3:0] col_s, digit;

  kp_row_scan #(.PRESC_W(PRESC_W)) u_scan (
    .clk_i(clk_i), .rst_ni(rst_ni), .row_o(row_o),
    .row_idx_o(row_idx), .step_o(step), .last_o(last)
  );

  kp_col_sync #(.W(KP_N), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(col_i), .q_o(col_s)
  );

  kp_debounce #(.DEB_FRAMES(DEB_FRAMES)) u_deb (
    .clk_i(clk_i), .rst_ni(rst_ni), .step_i(step), .last_i(last),
    .row_idx_i(row_idx), .col_i(col_s),
    .valid_o(key_valid_o), .seen_o(seen), .digit_o(digit)
  );

  assign seg_o      = seen ? {1'b0, seg_of(digit)} : 8'h00;
  assign digit_en_o = 1'b1;

  AST_SEG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(seg_o) |-> key_valid_o); // R9
endmodule

// File: tb/hex_keypad_decoder_tb.sv
module hex_keypad_decoder_tb;
  localparam int PW    = 3;
  localparam int DEB   = 4;
  localparam int DWELL = 1 << PW;
  localparam int FRAME = 4 * DWELL;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [3:0] col, row;
  logic [7:0] seg;
  logic       en, kv;
  logic [15:0] press = '0;

  int compared = 0, mism = 0;
  int strobes = 0, width_err = 0, en_err = 0, seg_err = 0;
  logic kv_prev = 1'b0;
  logic [7:0] seg_prev = 8'h00;

  always #10 clk = ~clk;

  hex_keypad_decoder #(.PRESC_W(PW), .DEB_FRAMES(DEB), .SYNC_STAGES(2)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .col_i(col), .row_o(row),
    .seg_o(seg), .digit_en_o(en), .key_valid_o(kv)
  );

  // switch matrix model: press bit r*4+c shorts row r to column c
  always_comb begin
    col = 4'b1111;
    for (int r = 0; r < 4; r++)
      for (int c = 0; c < 4; c++)
        if (press[r*4+c] && !row[3-r]) col[3-c] = 1'b0;
  end

  function automatic int digit_at(input int k);
    int t [16] = '{1, 2, 3, 15, 4, 5, 6, 14, 7, 8, 9, 13, 0, 10, 11, 12};
    return t[k];
  endfunction

  function automatic int seg_exp(input int d);
    int t [16] = '{'h3F, 'h06, 'h5B, 'h4F, 'h66, 'h6D, 'h7D, 'h07,
                   'h7F, 'h6F, 'h77, 'h7C, 'h39, 'h5E, 'h79, 'h71};
    return t[d];
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    compared++;
    if (act !== exp) begin
      mism++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_ni) begin
    if (kv) strobes++;
    if (kv && kv_prev) width_err++;
    if (en !== 1'b1) en_err++;
    if (seg !== seg_prev && !kv) seg_err++;
    kv_prev  <= kv;
    seg_prev <= seg;
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // press key(s), hold, release; returns strobes seen over the window
  task automatic hit(input logic [15:0] m, input int hold, input int rel, output int got);
    int b;
    b = strobes;
    press = m;
    cyc(hold);
    press = '0;
    cyc(rel);
    got = strobes - b;
  endtask

  initial begin
    int got, n;
    logic [3:0] prev, expn;
    cyc(3);
    chk("R1 reset row", int'(row), 4'b1110);
    chk("R9 reset seg", int'(seg), 0);
    chk("R6 reset strobe", int'(kv), 0);
    chk("R10 reset enable", int'(en), 1);
    rst_ni = 1'b1;

    // R1/R2: ring order and dwell
    prev = row;
    while (row == prev) @(negedge clk);
    for (int s = 0; s < 8; s++) begin
      prev = row; n = 0;
      expn = {prev[0], prev[3:1]};
      while (row == prev) begin @(negedge clk); n++; end
      chk("R1 row order", int'(row), int'(expn));
      chk("R2 dwell", n, DWELL);
    end

    // R3/R4/R5/R6: every key once
    for (int k = 0; k < 16; k++) begin
      hit(16'(1) << k, 8*FRAME, 8*FRAME, got);
      chk("R6 one strobe per key", got, 1);
      chk("R3 R4 key segment", int'(seg), seg_exp(digit_at(k)));
    end

    // R5: short press ignored
    hit(16'(1) << 5, 40, 8*FRAME, got);
    chk("R5 short press strobe", got, 0);
    chk("R5 short press seg", int'(seg), 'h39);

    // R6: long hold, no repeat
    hit(16'(1) << 9, 20*FRAME, 8*FRAME, got);
    chk("R6 long hold strobe", got, 1);
    chk("R6 long hold seg", int'(seg), seg_exp(digit_at(9)));

    // R7: short release blocks the next press
    hit(16'(1) << 0, 8*FRAME, 50, got);
    chk("R7 first press", got, 1);
    hit(16'(1) << 1, 8*FRAME, 8*FRAME, got);
    chk("R7 early repress strobe", got, 0);
    chk("R7 early repress seg", int'(seg), 'h06);
    hit(16'(1) << 1, 8*FRAME, 8*FRAME, got);
    chk("R7 rearmed press", got, 1);
    chk("R7 rearmed seg", int'(seg), 'h5B);

    // R8: chords rejected
    hit(16'h0003, 8*FRAME, 8*FRAME, got);
    chk("R8 same-row chord strobe", got, 0);
    chk("R8 same-row chord seg", int'(seg), 'h5B);
    hit(16'h0410, 8*FRAME, 8*FRAME, got);
    chk("R8 cross-row chord strobe", got, 0);
    chk("R8 cross-row chord seg", int'(seg), 'h5B);
    hit(16'(1) << 4, 8*FRAME, 8*FRAME, got);
    chk("R8 single after chord", int'(seg), 'h66);

    // R5/R6: bounce then stable hold
    got = strobes;
    for (int i = 0; i < 40; i++) begin
      press = (i % 2 == 0) ? 16'(1) << 14 : 16'h0;
      cyc(3);
    end
    press = 16'(1) << 14;
    cyc(8*FRAME);
    press = '0;
    cyc(8*FRAME);
    chk("R6 bounce single strobe", strobes - got, 1);
    chk("R5 bounce seg", int'(seg), 'h7C);

    chk("R6 strobe width", width_err, 0);
    chk("R10 enable constant", en_err, 0);
    chk("R9 seg only on strobe", seg_err, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mism);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    compared++;
    mism++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mism);
    $finish;
  end
endmodule